// File: doc/BRIEF.md
# CAN Receive Buffer Slot Controller

This block owns one receive slot of a CAN controller. A protocol engine hands it fully decoded frames: identifier, identifier type (standard or extended), remote-request flag, error flag, data length, payload, and the index of the acceptance filter that matched. For each frame the block applies a two-bit receive mode and decides whether the frame belongs in the slot. An accepted frame is stored together with its status, the slot locks, and an interrupt flag rises. The slot stays locked, and every further frame aimed at it is discarded, until software releases it.

Software sees the full flag, the interrupt flag and the captured status and payload as plain output pins, and has two single-cycle strobes: one releases the slot, the other acknowledges the interrupt. An interrupt acknowledged while the slot is still locked comes back, so a pending frame cannot be forgotten.

The frame input is a valid-only stream. A CAN bus cannot be paused, so there is no ready signal and no back-pressure: a frame presented while the slot is locked, or in the same cycle as a release, is dropped rather than held. Each cycle with `fr_valid` high carries exactly one complete frame.

Top module: `can_rx_slot`

## Requirements
- R1: After reset `full`, `irq`, `st_rtr`, `st_ext`, `st_hit`, `st_id`, `st_dlc` and `st_data` are all 0.
- R2: With `enh_mode`=0 and `rx_mode`=2'b11, every presented frame is accepted, including frames with `fr_err`=1, whatever the filter setting.
- R3: With `enh_mode`=0 and `rx_mode`=2'b10, a frame is accepted only if `fr_err`=0, `fr_ext`=1 and bit `fr_hit` of `filt_ext` is 1.
- R4: With `enh_mode`=0 and `rx_mode`=2'b01, a frame is accepted only if `fr_err`=0, `fr_ext`=0 and bit `fr_hit` of `filt_ext` is 0.
- R5: With `enh_mode`=0 and `rx_mode`=2'b00, a frame is accepted only if `fr_err`=0 and `fr_ext` equals bit `fr_hit` of `filt_ext`; in every mode other than accept-all, an error frame is rejected.
- R6: With `enh_mode`=1 only `rx_mode[1]` matters: 1 accepts every frame as in R2, 0 applies the R5 rule.
- R7: An accepted frame arriving while the slot is empty sets `full` and `irq` at the next clock edge, and in that same edge all status and payload outputs take the frame's values.
- R8: While `full`=1 no frame is loaded: `full` stays 1 and all status and payload outputs keep their values.
- R9: `clr_full`=1 clears `full` at the next edge; a frame presented in that same cycle is dropped, and the next accepted frame after the release is loaded.
- R10: `clr_irq`=1 clears `irq` at the next edge; if `full` is still 1 then, `irq` is 1 again one edge later. A load in the same cycle as `clr_irq` leaves `irq`=1.
- R11: On a load `st_rtr` takes `fr_rtr`, `st_ext` takes `fr_ext`, and `st_hit` takes `fr_hit` when `enh_mode`=1 and 0 when `enh_mode`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fr_valid | input | 1 | A complete frame is presented this cycle |
| fr_ext | input | 1 | Frame carries an extended identifier |
| fr_rtr | input | 1 | Frame is a remote request |
| fr_err | input | 1 | Frame was received with an error |
| fr_hit | input | 5 | Index of the matching acceptance filter |
| fr_id | input | 29 | Frame identifier |
| fr_dlc | input | 4 | Data length code |
| fr_data | input | 64 | Payload, byte 0 in the low bits |
| rx_mode | input | 2 | Receive mode select |
| enh_mode | input | 1 | Enhanced operation: filter index recorded, mode bit 0 ignored |
| filt_ext | input | 32 | Per-filter extended-identifier enable |
| clr_full | input | 1 | Software strobe releasing the slot |
| clr_irq | input | 1 | Software strobe acknowledging the interrupt |
| full | output | 1 | Slot holds a frame and is locked |
| irq | output | 1 | Receive interrupt flag |
| st_rtr | output | 1 | Captured remote-request bit |
| st_ext | output | 1 | Captured identifier type |
| st_hit | output | 5 | Captured filter index |
| st_id | output | 29 | Captured identifier |
| st_dlc | output | 4 | Captured data length code |
| st_data | output | 64 | Captured payload |

## Verification
Both flags are registers driven straight onto pins, so a wrong lock or interrupt state shows at `full` or `irq` one edge after the cycle that caused it, and the bench compares them every cycle. A wrong acceptance decision surfaces at `full` one edge after the frame. A wrong captured status or payload is only visible after a load, but stays visible for the whole locked period, and a frame loaded while locked shows as changed status on the next edge.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;

  typedef enum logic [1:0] {
    RXM_FILTER = 2'b00,
    RXM_STD    = 2'b01,
    RXM_EXT    = 2'b10,
    RXM_ANY    = 2'b11
  } rx_mode_e;

  // Maps the software mode pins onto the rule actually applied.
  function automatic rx_mode_e effective_mode(input logic [1:0] mode, input logic enh);
    if (enh) return mode[1] ? RXM_ANY : RXM_FILTER;
    return rx_mode_e'(mode);
  endfunction

endpackage

// File: rtl/can_rx_accept.sv
module can_rx_accept
  import can_rx_pkg::*;
#(
  parameter int FILT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fr_valid,
  input  logic              fr_ext,
  input  logic              fr_err,
  input  logic [FILT_W-1:0] fr_hit,
  input  logic [(1<<FILT_W)-1:0] filt_ext,
  input  logic [1:0]        rx_mode,
  input  logic              enh_mode,
  output logic              take
);
  localparam int NUM_FILT = 1 << FILT_W;

  rx_mode_e eff;
  logic     filt_is_ext;
  logic     ok;

  assign eff         = effective_mode(rx_mode, enh_mode);
  assign filt_is_ext = filt_ext[fr_hit];

  always_comb begin
    unique case (eff)
      RXM_ANY:    ok = 1'b1;
      RXM_EXT:    ok = !fr_err && fr_ext && filt_is_ext;
      RXM_STD:    ok = !fr_err && !fr_ext && !filt_is_ext;
      default:    ok = !fr_err && (fr_ext == filt_is_ext);
    endcase
  end

  assign take = fr_valid && ok;

  // R2 / R5: an error frame only passes in an accept-all setting
  a_r5_err_only_in_any: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fr_err) |-> (enh_mode ? rx_mode[1] : (rx_mode == 2'b11)));

  // R3 / R4: standard-only and extended-only never pass the other type
  a_r3_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !enh_mode && rx_mode == 2'b10) |-> fr_ext);
  a_r4_std_only: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !enh_mode && rx_mode == 2'b01) |-> !fr_ext);

  initial begin
    if (NUM_FILT != (1 << FILT_W)) $error("filter count mismatch");
  end

endmodule

// File: rtl/can_rx_lock.sv
module can_rx_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic clr_full,
  input  logic clr_irq,
  output logic load,
  output logic full,
  output logic irq
);
  // Release beats an arriving frame; the frame is then lost.
  assign load = take && !full && !clr_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
    end else if (load) begin
      full <= 1'b1;
    end else if (clr_full) begin
      full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else if (load) begin
      irq <= 1'b1;
    end else if (clr_irq) begin
      irq <= 1'b0;
    end else if (full && !irq && !clr_full) begin
      irq <= 1'b1;
    end
  end

  // R7: a load locks the slot and raises the interrupt
  a_r7_load_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (full && irq));

  // R9: a release always empties the slot
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_full |=> !full);

  // R8: the slot stays locked without a release
  a_r8_stay_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr_full) |=> full);

  // R10: an acknowledged interrupt returns while the slot is still locked
  a_r10_irq_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !irq && !clr_full && !clr_irq) |=> irq);
  a_r10_irq_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_irq && !take) |=> !irq);

endmodule

// File: rtl/can_rx_capture.sv
module can_rx_capture #(
  parameter int FILT_W     = 5,
  parameter int ID_W       = 29,
  parameter int DLC_W      = 4,
  parameter int DATA_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    slot_full,
  input  logic                    enh_mode,
  input  logic                    fr_rtr,
  input  logic                    fr_ext,
  input  logic [FILT_W-1:0]       fr_hit,
  input  logic [ID_W-1:0]         fr_id,
  input  logic [DLC_W-1:0]        fr_dlc,
  input  logic [DATA_BYTES*8-1:0] fr_data,
  output logic                    st_rtr,
  output logic                    st_ext,
  output logic [FILT_W-1:0]       st_hit,
  output logic [ID_W-1:0]         st_id,
  output logic [DLC_W-1:0]        st_dlc,
  output logic [DATA_BYTES*8-1:0] st_data
);
  localparam int DATA_W = DATA_BYTES * 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_rtr <= 1'b0;
      st_ext <= 1'b0;
      st_hit <= '0;
      st_id  <= '0;
      st_dlc <= '0;
    end else if (load) begin
      st_rtr <= fr_rtr;
      st_ext <= fr_ext;
      st_hit <= enh_mode ? fr_hit : '0;
      st_id  <= fr_id;
      st_dlc <= fr_dlc;
    end
  end

  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_data[b*8 +: 8] <= 8'h00;
      end else if (load) begin
        st_data[b*8 +: 8] <= fr_data[b*8 +: 8];
      end
    end
  end

  // R8: nothing captured changes while the slot is locked
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    slot_full |=> ($stable(st_id) && $stable(st_data) && $stable(st_dlc)
                   && $stable(st_rtr) && $stable(st_ext) && $stable(st_hit)));

  // R11: the filter index is recorded only in enhanced operation
  a_r11_hit_legacy: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !enh_mode) |=> (st_hit == '0));

  // R7: payload lands in the same edge as the load
  a_r7_payload: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (st_data == $past(fr_data[DATA_W-1:0])));

endmodule

// File: rtl/can_rx_slot.sv
module can_rx_slot
  import can_rx_pkg::*;
#(
  parameter int FILT_W     = 5,
  parameter int ID_W       = 29,
  parameter int DLC_W      = 4,
  parameter int DATA_BYTES = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fr_valid,
  input  logic                        fr_ext,
  input  logic                        fr_rtr,
  input  logic                        fr_err,
  input  logic [FILT_W-1:0]           fr_hit,
  input  logic [ID_W-1:0]             fr_id,
  input  logic [DLC_W-1:0]            fr_dlc,
  input  logic [DATA_BYTES*8-1:0]     fr_data,
  input  logic [1:0]                  rx_mode,
  input  logic                        enh_mode,
  input  logic [(1<<FILT_W)-1:0]      filt_ext,
  input  logic                        clr_full,
  input  logic                        clr_irq,
  output logic                        full,
  output logic                        irq,
  output logic                        st_rtr,
  output logic                        st_ext,
  output logic [FILT_W-1:0]           st_hit,
  output logic [ID_W-1:0]             st_id,
  output logic [DLC_W-1:0]            st_dlc,
  output logic [DATA_BYTES*8-1:0]     st_data
);
  logic take;
  logic load;

  can_rx_accept #(.FILT_W(FILT_W)) u_accept (
    .clk      (clk),
    .rst_n    (rst_n),
    .fr_valid (fr_valid),
    .fr_ext   (fr_ext),
    .fr_err   (fr_err),
    .fr_hit   (fr_hit),
    .filt_ext (filt_ext),
    .rx_mode  (rx_mode),
    .enh_mode (enh_mode),
    .take     (take)
  );

  can_rx_lock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .clr_full (clr_full),
    .clr_irq  (clr_irq),
    .load     (load),
    .full     (full),
    .irq      (irq)
  );

  can_rx_capture #(
    .FILT_W     (FILT_W),
    .ID_W       (ID_W),
    .DLC_W      (DLC_W),
    .DATA_BYTES (DATA_BYTES)
  ) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .slot_full (full),
    .enh_mode  (enh_mode),
    .fr_rtr    (fr_rtr),
    .fr_ext    (fr_ext),
    .fr_hit    (fr_hit),
    .fr_id     (fr_id),
    .fr_dlc    (fr_dlc),
    .fr_data   (fr_data),
    .st_rtr    (st_rtr),
    .st_ext    (st_ext),
    .st_hit    (st_hit),
    .st_id     (st_id),
    .st_dlc    (st_dlc),
    .st_data   (st_data)
  );

  // R9: a frame arriving with a release is not stored
  a_r9_drop_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_full && fr_valid) |=> !full);

endmodule

// File: tb/test_can_rx_slot.sv
module test_can_rx_slot;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fr_valid = 0, fr_ext = 0, fr_rtr = 0, fr_err = 0;
  logic [4:0]  fr_hit = '0;
  logic [28:0] fr_id = '0;
  logic [3:0]  fr_dlc = '0;
  logic [63:0] fr_data = '0;
  logic [1:0]  rx_mode = '0;
  logic        enh_mode = 0;
  logic [31:0] filt_ext = '0;
  logic        clr_full = 0, clr_irq = 0;
  logic        full, irq, st_rtr, st_ext;
  logic [4:0]  st_hit;
  logic [28:0] st_id;
  logic [3:0]  st_dlc;
  logic [63:0] st_data;

  int total = 0;
  int bad = 0;

  // reference state
  logic        m_full = 0, m_irq = 0, m_rtr = 0, m_ext = 0;
  logic [4:0]  m_hit = '0;
  logic [28:0] m_id = '0;
  logic [3:0]  m_dlc = '0;
  logic [63:0] m_data = '0;

  always #4 clk = ~clk;

  can_rx_slot i_can_rx_slot (
    .clk(clk), .rst_n(rst_n), .fr_valid(fr_valid), .fr_ext(fr_ext), .fr_rtr(fr_rtr),
    .fr_err(fr_err), .fr_hit(fr_hit), .fr_id(fr_id), .fr_dlc(fr_dlc), .fr_data(fr_data),
    .rx_mode(rx_mode), .enh_mode(enh_mode), .filt_ext(filt_ext), .clr_full(clr_full),
    .clr_irq(clr_irq), .full(full), .irq(irq), .st_rtr(st_rtr), .st_ext(st_ext),
    .st_hit(st_hit), .st_id(st_id), .st_dlc(st_dlc), .st_data(st_data)
  );

  function automatic logic accepts(input logic [1:0] mode, input logic enh,
                                   input logic ext, input logic err, input logic fx);
    logic [1:0] m;
    m = enh ? (mode[1] ? 2'b11 : 2'b00) : mode;
    case (m)
      2'b11:   return 1'b1;
      2'b10:   return !err && ext && fx;
      2'b01:   return !err && !ext && !fx;
      default: return !err && (ext == fx);
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "full", 64'(full), 64'(m_full));
    chk(tag, "irq", 64'(irq), 64'(m_irq));
    chk(tag, "st_rtr", 64'(st_rtr), 64'(m_rtr));
    chk(tag, "st_ext", 64'(st_ext), 64'(m_ext));
    chk(tag, "st_hit", 64'(st_hit), 64'(m_hit));
    chk(tag, "st_id", 64'(st_id), 64'(m_id));
    chk(tag, "st_dlc", 64'(st_dlc), 64'(m_dlc));
    chk(tag, "st_data", st_data, m_data);
  endtask

  // one clock: model follows the inputs at the edge, outputs checked at the falling edge
  task automatic tick(input string tag);
    logic acc, ld;
    @(posedge clk);
    acc = fr_valid && accepts(rx_mode, enh_mode, fr_ext, fr_err, filt_ext[fr_hit]);
    ld  = acc && !m_full && !clr_full;
    if (ld) begin
      m_rtr = fr_rtr; m_ext = fr_ext; m_hit = enh_mode ? fr_hit : 5'd0;
      m_id = fr_id; m_dlc = fr_dlc; m_data = fr_data;
    end
    if (ld) m_irq = 1'b1;
    else if (clr_irq) m_irq = 1'b0;
    else if (m_full && !m_irq && !clr_full) m_irq = 1'b1;
    if (ld) m_full = 1'b1;
    else if (clr_full) m_full = 1'b0;
    @(negedge clk);
    fr_valid = 0; clr_full = 0; clr_irq = 0;
    compare(tag);
  endtask

  task automatic frame(input logic ext, input logic err, input logic rtr,
                       input logic [4:0] hit, input logic [28:0] id);
    fr_valid = 1; fr_ext = ext; fr_err = err; fr_rtr = rtr; fr_hit = hit; fr_id = id;
    fr_dlc = id[3:0]; fr_data = {id[27:0], 7'h2a, id};
  endtask

  task automatic release_slot();
    clr_full = 1; clr_irq = 1;
    tick("R9");
    chk("R9", "full after release", 64'(full), 64'd0);
  endtask

  initial begin
    void'($urandom(32'h0000_5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1");
    chk("R1", "full at reset", 64'(full), 64'd0);
    chk("R1", "irq at reset", 64'(irq), 64'd0);

    // R2: accept-all takes an error frame
    rx_mode = 2'b11; enh_mode = 0; filt_ext = 32'h0000_0080;
    frame(0, 1, 1, 5'd5, 29'h0123_4567);
    tick("R2");
    chk("R2", "error frame loaded", 64'(full), 64'd1);
    chk("R11", "rtr captured", 64'(st_rtr), 64'd1);
    chk("R11", "hit zero in legacy", 64'(st_hit), 64'd0);
    chk("R7", "irq with load", 64'(irq), 64'd1);
    release_slot();

    // R5: filter-driven mode rejects an error frame
    rx_mode = 2'b00;
    frame(1, 1, 0, 5'd7, 29'h0abc_def0);
    tick("R5");
    chk("R5", "error frame dropped", 64'(full), 64'd0);

    // R3: extended only
    rx_mode = 2'b10;
    frame(1, 0, 0, 5'd3, 29'h1111_1111);
    tick("R3");
    chk("R3", "filter not extended", 64'(full), 64'd0);
    frame(1, 0, 0, 5'd7, 29'h1222_2222);
    tick("R3");
    chk("R3", "extended accepted", 64'(full), 64'd1);
    release_slot();

    // R4: standard only
    rx_mode = 2'b01;
    frame(0, 0, 0, 5'd7, 29'h0000_0333);
    tick("R4");
    chk("R4", "filter extended", 64'(full), 64'd0);
    frame(0, 0, 1, 5'd2, 29'h0000_0444);
    tick("R4");
    chk("R4", "standard accepted", 64'(full), 64'd1);
    release_slot();

    // R6: enhanced ignores mode bit 0
    enh_mode = 1; rx_mode = 2'b01;
    frame(1, 0, 0, 5'd7, 29'h1555_5555);
    tick("R6");
    chk("R6", "acts as filter-driven", 64'(full), 64'd1);
    chk("R11", "hit recorded", 64'(st_hit), 64'd7);
    chk("R11", "ext captured", 64'(st_ext), 64'd1);
    release_slot();
    rx_mode = 2'b10;
    frame(0, 1, 0, 5'd9, 29'h0666_0666);
    tick("R6");
    chk("R6", "accept-all in enhanced", 64'(full), 64'd1);

    // R8: locked slot drops a new frame
    frame(1, 0, 1, 5'd1, 29'h1777_7777);
    tick("R8");
    chk("R8", "id kept", 64'(st_id), 64'h0666_0666);

    // R10: acknowledged interrupt returns
    clr_irq = 1;
    tick("R10");
    chk("R10", "irq cleared", 64'(irq), 64'd0);
    tick("R10");
    chk("R10", "irq re-set", 64'(irq), 64'd1);

    // R9: release together with a frame drops it, next frame loads
    clr_full = 1;
    frame(1, 0, 0, 5'd4, 29'h1888_8888);
    tick("R9");
    chk("R9", "frame with release dropped", 64'(full), 64'd0);
    frame(1, 0, 0, 5'd4, 29'h1999_9999);
    tick("R9");
    chk("R9", "next frame loaded", 64'(full), 64'd1);
    chk("R7", "id of next frame", 64'(st_id), 64'h1999_9999);
    release_slot();

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      if (n % 200 == 0) begin
        filt_ext = $urandom;
        enh_mode = 1'($urandom);
      end
      rx_mode = 2'($urandom);
      if ($urandom % 10 < 4) begin
        frame(1'($urandom), ($urandom % 5 == 0), 1'($urandom), 5'($urandom), 29'($urandom));
        fr_data = {$urandom, $urandom};
      end
      clr_full = ($urandom % 10 == 0);
      clr_irq  = ($urandom % 7 == 0);
      tick("R7");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule